// File: doc/BRIEF.md
# Two-Stage Packed-BCD Adder/Subtractor

This block adds or subtracts two packed-BCD operands, one decimal digit per nibble with the least significant digit in bits [3:0]. A carry input is added on addition. On subtraction the same input acts as an inverted borrow. The default width is two digits (8 bits). The digit count is a parameter: 2 to 8 digits are supported, and the decimal-adjust flag of each digit ripples from the digit below it.

The work is split over one pipeline register. The first stage forms the plain binary sum, or the binary difference computed as A + ~B + carry. It registers that value together with, for each nibble, the carry out of the nibble and whether the nibble is above 8 or above 9. The second stage works only from these registered values. It derives a decimal-adjust flag per digit and adds a correction word, which gives the packed-BCD result and the decimal carry.

The block accepts an operation on every clock edge at which `in_valid` is high. Its result and `out_valid` appear after that edge. There is no back-pressure in either direction: the block never refuses an input, so no ready signal goes upstream, and the consumer must take each result in the cycle it is presented. When `in_valid` is low at an edge, the block holds its last result and lowers `out_valid`.

Top module: `bcd_addsub`

## Requirements
- R1: With `in_sub`=0, `out_result` is the packed-BCD value of (A + B + `in_carry`) mod 10^DIGITS. A and B are the decimal values of the BCD operands.
- R2: With `in_sub`=1, `out_result` is the packed-BCD value of (A - B - (1 - `in_carry`)) mod 10^DIGITS.
- R3: On addition, `out_carry` is 1 exactly when A + B + `in_carry` is at least 10^DIGITS.
- R4: On subtraction, `out_carry` is 1 exactly when no borrow occurs, that is when A >= B + (1 - `in_carry`).
- R5: `in_sub`=0 selects addition and `in_sub`=1 selects subtraction. `in_carry` counts as +1 on addition and as not-borrow on subtraction.
- R6: `out_valid` equals the `in_valid` sampled at the previous clock edge. The result of inputs sampled at an edge is presented after that same edge, and a new operation can be accepted at every edge.
- R7: After a clock edge with `rst` high (synchronous, active high), `out_valid`=0, `out_result`=0 and `out_carry`=0.
- R8: At an edge with `in_valid` low, `out_result` and `out_carry` keep their previous values, whatever the operand inputs are.
- R9: For BCD operands, every digit of `out_result` lies in 0..9.
- R10: When the correction of a lower digit carries into an upper digit that holds 9, that upper digit is also corrected. Examples: 0x95+0x05 gives 0x00 with carry 1, and 0x58+0x47 gives 0x05 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| in_carry | input | 1 | Carry-in (add) / not-borrow (subtract) |
| in_a | input | 4*DIGITS | First packed-BCD operand |
| in_b | input | 4*DIGITS | Second packed-BCD operand |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | 4*DIGITS | Packed-BCD result |
| out_carry | output | 1 | Decimal carry-out / not-borrow |

## Verification
The operand patterns are chosen so that each one selects a different pair of decimal-adjust flags: no adjustment, low digit only, high digit only, and both. On addition they separate a binary carry out of a nibble from a nibble above 9. They also cover the rippled case, where the low-digit fix carries into a 9 in the upper digit. Subtraction patterns separate borrow from no borrow in each digit, including results that wrap below zero. Each operand pair is run with both carry-in values, which shows that the carry input is an increment on addition and an inverted borrow on subtraction. Idle cycles with changing operands and a reset in the middle of a stream show the hold and clear behaviour at the ports.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } bcd_op_e;

  localparam int MAX_DIGITS = 8;

  function automatic int unsigned pow10(input int digits);
    int unsigned p;
    p = 1;
    for (int i = 0; i < digits; i++) p = p * 10;
    return p;
  endfunction

  function automatic bit is_bcd(input logic [31:0] v, input int digits);
    for (int i = 0; i < MAX_DIGITS; i++)
      if (i < digits && v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int unsigned dec_value(input logic [31:0] v, input int digits);
    int unsigned acc;
    acc = 0;
    for (int i = MAX_DIGITS - 1; i >= 0; i--)
      if (i < digits) acc = acc * 10 + 32'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic logic [31:0] to_bcd(input int unsigned v, input int digits);
    logic [31:0] r;
    int unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < MAX_DIGITS; i++)
      if (i < digits) begin
        r[4*i +: 4] = 4'(t % 10);
        t = t / 10;
      end
    return r;
  endfunction

endpackage

// File: rtl/bcd_bin_stage.sv
module bcd_bin_stage
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  bcd_op_e           in_op,
  input  logic              in_carry,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  output logic              q_valid,
  output bcd_op_e           q_op,
  output logic [W-1:0]      q_sum,
  output logic [DIGITS-1:0] q_ncarry,
  output logic [DIGITS-1:0] q_gt9,
  output logic [DIGITS-1:0] q_gt8
);

  logic [W-1:0]      b_eff;
  logic [W-1:0]      sum_d;
  logic [DIGITS:0]   chain;
  logic [DIGITS-1:0] gt9_d;
  logic [DIGITS-1:0] gt8_d;

  assign b_eff    = (in_op == OP_SUB) ? ~in_b : in_b;
  assign chain[0] = in_carry;

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    logic [4:0] nsum;
    assign nsum            = {1'b0, in_a[4*g +: 4]} + {1'b0, b_eff[4*g +: 4]} + {4'd0, chain[g]};
    assign sum_d[4*g +: 4] = nsum[3:0];
    assign chain[g+1]      = nsum[4];
    assign gt9_d[g]        = nsum[3:0] > 4'd9;
    assign gt8_d[g]        = nsum[3:0] > 4'd8;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_op     <= OP_ADD;
      q_sum    <= '0;
      q_ncarry <= '0;
      q_gt9    <= '0;
      q_gt8    <= '0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) begin
        q_op     <= in_op;
        q_sum    <= sum_d;
        q_ncarry <= chain[DIGITS:1];
        q_gt9    <= gt9_d;
        q_gt8    <= gt8_d;
      end
    end
  end

  // R8: an idle edge leaves the stage-one state untouched
  a_r8_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(q_sum) && $stable(q_ncarry) && $stable(q_op)));

  // R7: reset clears the registered partial result
  a_r7_stage_clear: assert property (@(posedge clk)
    rst |=> (!q_valid && q_sum == '0 && q_ncarry == '0));

endmodule

// File: rtl/bcd_adjust_flags.sv
module bcd_adjust_flags
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  bcd_op_e           op,
  input  logic [DIGITS-1:0] ncarry,
  input  logic [DIGITS-1:0] gt9,
  input  logic [DIGITS-1:0] gt8,
  output logic [DIGITS-1:0] adj
);

  // Each digit's flag depends on the flag and carry of the digit below it.
  always_comb begin
    logic prev_adj;
    logic prev_nc;
    prev_adj = 1'b0;
    prev_nc  = 1'b1;
    adj      = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (op == OP_SUB)
        adj[i] = ~ncarry[i] | (prev_adj & gt9[i]);
      else
        adj[i] = ncarry[i] | gt9[i] | (prev_adj & ~prev_nc & gt8[i]);
      prev_adj = adj[i];
      prev_nc  = ncarry[i];
    end
  end

endmodule

// File: rtl/bcd_correct.sv
module bcd_correct
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  bcd_op_e           op,
  input  logic [W-1:0]      sum,
  input  logic [DIGITS-1:0] adj,
  input  logic              top_ncarry,
  output logic [W-1:0]      result,
  output logic              carry
);

  logic [W-1:0] corr;
  logic [W-1:0] corr_signed;

  always_comb begin
    corr = '0;
    for (int i = 0; i < DIGITS; i++)
      if (adj[i]) corr = corr | (W'(6) << (4 * i));
  end

  assign corr_signed = (op == OP_SUB) ? (~corr + W'(1)) : corr;
  assign result      = sum + corr_signed;
  assign carry       = (op == OP_SUB) ? top_ncarry : adj[DIGITS-1];

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_sub,
  input  logic         in_carry,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_carry
);

  bcd_op_e           in_op;
  bcd_op_e           q_op;
  logic [W-1:0]      q_sum;
  logic [DIGITS-1:0] q_ncarry;
  logic [DIGITS-1:0] q_gt9;
  logic [DIGITS-1:0] q_gt8;
  logic [DIGITS-1:0] adj;

  assign in_op = in_sub ? OP_SUB : OP_ADD;

  bcd_bin_stage #(.DIGITS(DIGITS)) i_bin (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_carry (in_carry),
    .in_a     (in_a),
    .in_b     (in_b),
    .q_valid  (out_valid),
    .q_op     (q_op),
    .q_sum    (q_sum),
    .q_ncarry (q_ncarry),
    .q_gt9    (q_gt9),
    .q_gt8    (q_gt8)
  );

  bcd_adjust_flags #(.DIGITS(DIGITS)) i_flags (
    .op     (q_op),
    .ncarry (q_ncarry),
    .gt9    (q_gt9),
    .gt8    (q_gt8),
    .adj    (adj)
  );

  bcd_correct #(.DIGITS(DIGITS)) i_corr (
    .op         (q_op),
    .sum        (q_sum),
    .adj        (adj),
    .top_ncarry (q_ncarry[DIGITS-1]),
    .result     (out_result),
    .carry      (out_carry)
  );

  // ---------------- decimal reference for the assertions ----------------
  localparam int unsigned LIMIT = pow10(DIGITS);
  logic              ops_bcd;
  int unsigned       da_val, db_val, ref_add, ref_sub_raw;
  logic [W-1:0]      ref_res;
  logic              ref_carry;

  always_comb begin
    ops_bcd = is_bcd(32'(in_a), DIGITS) && is_bcd(32'(in_b), DIGITS);
    da_val  = dec_value(32'(in_a), DIGITS);
    db_val  = dec_value(32'(in_b), DIGITS);
    ref_add = da_val + db_val + 32'(in_carry);
    ref_sub_raw = da_val + LIMIT - db_val - 32'(!in_carry);
    if (in_sub) begin
      ref_res   = W'(to_bcd(ref_sub_raw % LIMIT, DIGITS));
      ref_carry = ref_sub_raw >= LIMIT;
    end else begin
      ref_res   = W'(to_bcd(ref_add % LIMIT, DIGITS));
      ref_carry = ref_add >= LIMIT;
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && !out_carry));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_carry)));

  a_r1_add_value: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sub && ops_bcd) |=> (out_result == $past(ref_res)));

  a_r2_sub_value: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sub && ops_bcd) |=> (out_result == $past(ref_res)));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sub && ops_bcd) |=> (out_carry == $past(ref_carry)));

  a_r4_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sub && ops_bcd) |=> (out_carry == $past(ref_carry)));

  a_r9_digits_decimal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ops_bcd) |=> is_bcd(32'(out_result), DIGITS));

endmodule

// File: tb/test_bcd_addsub.sv
module test_bcd_addsub;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_sub;
  logic       in_carry;
  logic [7:0] in_a;
  logic [7:0] in_b;
  logic       out_valid;
  logic [7:0] out_result;
  logic       out_carry;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_addsub #(.DIGITS(2)) i_bcd_addsub (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sub     (in_sub),
    .in_carry   (in_carry),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
  );

  // {sub, cin, a, b, expected result, expected carry}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h99, 8'h01, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0},
    {1'b0, 1'b1, 8'h45, 8'h54, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h58, 8'h47, 8'h05, 1'b1},
    {1'b0, 1'b0, 8'h95, 8'h05, 8'h00, 1'b1},
    {1'b0, 1'b1, 8'h99, 8'h99, 8'h99, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h19, 8'h01, 8'h20, 1'b0},
    {1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 1'b0},
    {1'b1, 1'b1, 8'h50, 8'h25, 8'h25, 1'b1},
    {1'b1, 1'b0, 8'h50, 8'h25, 8'h24, 1'b1},
    {1'b1, 1'b1, 8'h25, 8'h50, 8'h75, 1'b0},
    {1'b1, 1'b1, 8'h42, 8'h42, 8'h00, 1'b1},
    {1'b1, 1'b0, 8'h00, 8'h00, 8'h99, 1'b0},
    {1'b1, 1'b1, 8'h91, 8'h19, 8'h72, 1'b1},
    {1'b1, 1'b1, 8'h10, 8'h01, 8'h09, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic c,
                       input logic [7:0] a, input logic [7:0] b);
    in_valid = v; in_sub = s; in_carry = c; in_a = a; in_b = b;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 reset valid",  16'(out_valid),  16'd0);
    check("R7 reset result", 16'(out_result), 16'h00);
    check("R7 reset carry",  16'(out_carry),  16'd0);
    rst = 1'b0;

    // back-to-back table walk: one operation per edge
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      drive(1'b1, v[26], v[25], v[24:17], v[16:9]);
      @(negedge clk);
      check("R6 valid follows", 16'(out_valid), 16'd1);
      if (v[26]) begin
        check($sformatf("R2 sub result vec %0d", i), 16'(out_result), 16'(v[8:1]));
        check($sformatf("R4 sub carry vec %0d", i),  16'(out_carry),  16'(v[0]));
      end else begin
        check($sformatf("R1 add result vec %0d", i), 16'(out_result), 16'(v[8:1]));
        check($sformatf("R3 add carry vec %0d", i),  16'(out_carry),  16'(v[0]));
      end
      check("R9 digits in range", 16'((out_result[3:0] <= 4'd9) && (out_result[7:4] <= 4'd9)), 16'd1);
    end

    // R5: same operands, carry-in toggled, on add and subtract
    drive(1'b1, 1'b0, 1'b0, 8'h45, 8'h54);
    @(negedge clk);
    check("R5 add cin=0 result", 16'({out_carry, out_result}), 16'h099);
    drive(1'b1, 1'b0, 1'b1, 8'h45, 8'h54);
    @(negedge clk);
    check("R5 add cin=1 result", 16'({out_carry, out_result}), 16'h100);
    drive(1'b1, 1'b1, 1'b0, 8'h37, 8'h37);
    @(negedge clk);
    check("R5 sub cin=0 borrows", 16'({out_carry, out_result}), 16'h099);
    drive(1'b1, 1'b1, 1'b1, 8'h37, 8'h37);
    @(negedge clk);
    check("R5 sub cin=1 no borrow", 16'({out_carry, out_result}), 16'h100);

    // R10: low-digit fix ripples into an upper 9
    drive(1'b1, 1'b0, 1'b0, 8'h91, 8'h09);
    @(negedge clk);
    check("R10 ripple 91+09", 16'({out_carry, out_result}), 16'h100);
    drive(1'b1, 1'b0, 1'b0, 8'h89, 8'h09);
    @(negedge clk);
    check("R10 no ripple 89+09", 16'({out_carry, out_result}), 16'h098);

    // R8: idle edges with changing operands hold the last result
    drive(1'b1, 1'b0, 1'b0, 8'h27, 8'h36);
    @(negedge clk);
    check("R1 add 27+36", 16'({out_carry, out_result}), 16'h063);
    drive(1'b0, 1'b1, 1'b1, 8'h99, 8'h11);
    @(negedge clk);
    check("R6 idle valid low", 16'(out_valid), 16'd0);
    check("R8 hold after idle", 16'({out_carry, out_result}), 16'h063);
    drive(1'b0, 1'b0, 1'b1, 8'h98, 8'h07);
    @(negedge clk);
    check("R8 hold second idle", 16'({out_carry, out_result}), 16'h063);

    // R7: reset in the middle of a stream
    drive(1'b1, 1'b0, 1'b1, 8'h99, 8'h99);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-stream valid",  16'(out_valid), 16'd0);
    check("R7 mid-stream result", 16'({out_carry, out_result}), 16'h000);
    rst = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 8'h00, 8'h99);
    @(negedge clk);
    check("R2 sub after reset", 16'({out_carry, out_result}), 16'h001);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule